// File: doc/BRIEF.md
# 64-bit Bit-Manipulation Integer Unit

This block is the integer execution slice for the register-to-register bit-manipulation group of a compact 16-bit instruction set. Each request carries an 8-bit operation code and two 64-bit operand values that have already been read from the register file. The first operand is the destination register's current value (called *D* below) and the second is the source register's value (called *S* below). The block returns the 64-bit value to write back one clock later, together with a strobe.

The operations fall into four families. The first is two-input logic and bit counting. The second is lane packing and sign extension. The third is shifts and rotates. The fourth is bit permutation: a generalized reverse, a butterfly shuffle, and parallel gather and scatter under a mask. Codes above 0x1B are not handled by this unit. For them the strobe stays low and the output keeps its previous value, so another unit can own them.

Top module: `bmx_alu`

## Requirements
- R1: `out_valid` is high in the cycle after a clock edge where `in_valid` was high and `in_op` was at most 0x1B. It is low after any other edge, including edges with codes 0x1C to 0xFF.
- R2: While `rst_n` is low, `out_valid` and `out_data` are both 0.
- R3: The logic codes are: 0x00 gives D&S, 0x01 gives D^S, 0x02 gives ~S, 0x03 gives D|S, 0x04 gives D&~S, 0x05 gives D^~S, and 0x07 gives D|~S.
- R4: Code 0x06 returns the number of set bits of S. A zero S gives 0.
- R5: Code 0x08 returns the number of leading zero bits of S and code 0x09 returns the number of trailing zero bits of S. Each gives 64 when S is zero.
- R6: The pack-low codes place the low lane of S directly above the low lane of D and zero the bits above both. Code 0x0A uses 32-bit lanes, 0x0C uses 16-bit lanes and 0x0E uses 8-bit lanes.
- R7: The pack-high codes do the same with the second lane from the bottom of each operand. Code 0x0B gives {S[63:32],D[63:32]}, 0x0D gives {S[31:16],D[31:16]} and 0x0F gives {S[15:8],D[15:8]}, each zero-extended to 64 bits.
- R8: Codes 0x10, 0x11 and 0x12 sign-extend the low 32, 16 and 8 bits of S to 64 bits.
- R9: Codes 0x13 to 0x17 shift or rotate D by S[5:0]: 0x13 is an arithmetic right shift, 0x14 a left shift, 0x15 a logical right shift, 0x16 a left rotate and 0x17 a right rotate. S[63:6] has no effect.
- R10: Code 0x18 returns D with result bit i equal to D[i XOR S[5:0]]. S[63:6] has no effect.
- R11: Code 0x19 applies butterfly stages to D, from S[4] down to S[0]. When S[k] is set, the stage exchanges bits k and k+1 of every bit index. S[63:5] has no effect.
- R12: Code 0x1A gathers the bits of D at the set positions of S, in ascending order, into the low end of the result. All other result bits are zero.
- R13: Code 0x1B scatters the low bits of D, in ascending order, into the set positions of S. All other result bits are zero.
- R14: When `out_valid` is low after reset, `out_data` keeps the value it had in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 8 | Operation code |
| in_dst | input | 64 | Destination operand value (D) |
| in_src | input | 64 | Source operand value (S) |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_data | output | 64 | Result value |

## Verification
The bench sweeps every shift amount, every reverse control and every shuffle control while random garbage sits in the unused upper bits of S. A design that decoded too many control bits would therefore produce wrong results only for some of those values. Zero, all-ones, single-bit and sign-boundary operands target the count edge cases (64 for an empty word) and the sign-extension boundaries, where an off-by-one lane or a missing zero case shows up as a result off by one bit or one lane. All 228 unhandled codes are driven, and idle cycles are inserted between requests. A decoder that accepted too wide a range would raise a strobe or overwrite the held result in those cycles.

// File: rtl/bmx_pkg.sv
package bmx_pkg;

  localparam int unsigned WORD_W = 64;

  // Operation codes; the numeric order is fixed by the instruction encoding.
  typedef enum logic [7:0] {
    OP_AND     = 8'h00,
    OP_XOR     = 8'h01,
    OP_INV     = 8'h02,
    OP_OR      = 8'h03,
    OP_ANDN    = 8'h04,
    OP_XNOR    = 8'h05,
    OP_PCNT    = 8'h06,
    OP_ORN     = 8'h07,
    OP_LZC     = 8'h08,
    OP_TZC     = 8'h09,
    OP_PKW_LO  = 8'h0A,
    OP_PKW_HI  = 8'h0B,
    OP_PKH_LO  = 8'h0C,
    OP_PKH_HI  = 8'h0D,
    OP_PKB_LO  = 8'h0E,
    OP_PKB_HI  = 8'h0F,
    OP_SXW     = 8'h10,
    OP_SXH     = 8'h11,
    OP_SXB     = 8'h12,
    OP_SRA     = 8'h13,
    OP_SLL     = 8'h14,
    OP_SRL     = 8'h15,
    OP_ROTL    = 8'h16,
    OP_ROTR    = 8'h17,
    OP_GREV    = 8'h18,
    OP_SHFL    = 8'h19,
    OP_GATHER  = 8'h1A,
    OP_SCATTER = 8'h1B
  } bmx_op_e;

  // Last code of each functional family; the decoder splits on these.
  localparam logic [7:0] LAST_BITWISE = 8'h12;
  localparam logic [7:0] LAST_SHIFT   = 8'h19;
  localparam logic [7:0] LAST_OP      = 8'h1B;

endpackage

// File: rtl/bmx_bitwise_unit.sv
// Logic, bit counting, lane packing and sign extension (codes 0x00..0x12).
module bmx_bitwise_unit
  import bmx_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic [7:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  localparam int unsigned LANE_W = W / 2;
  localparam int unsigned LANE_H = W / 4;
  localparam int unsigned LANE_B = W / 8;

  function automatic logic [W-1:0] ones_below(input int unsigned n);
    return {W{1'b1}} >> (W - n);
  endfunction

  function automatic logic [W-1:0] set_count(input logic [W-1:0] x);
    int unsigned n = 0;
    for (int i = 0; i < W; i++) n += int'(x[i]);
    return W'(n);
  endfunction

  // Highest set bit wins because later iterations overwrite.
  function automatic logic [W-1:0] lead_zeros(input logic [W-1:0] x);
    int unsigned n = W;
    for (int i = 0; i < W; i++) if (x[i]) n = W - 1 - i;
    return W'(n);
  endfunction

  // Lowest set bit wins because the loop runs downward.
  function automatic logic [W-1:0] trail_zeros(input logic [W-1:0] x);
    int unsigned n = W;
    for (int i = W - 1; i >= 0; i--) if (x[i]) n = i;
    return W'(n);
  endfunction

  function automatic logic [W-1:0] pack_lanes(input logic [W-1:0] d,
                                              input logic [W-1:0] s,
                                              input int unsigned lane,
                                              input logic upper);
    logic [W-1:0] m = ones_below(lane);
    logic [W-1:0] dl = upper ? (d >> lane) : d;
    logic [W-1:0] sl = upper ? (s >> lane) : s;
    return ((sl & m) << lane) | (dl & m);
  endfunction

  function automatic logic [W-1:0] sign_from(input logic [W-1:0] x,
                                             input int unsigned n);
    logic [W-1:0] m = ones_below(n);
    return x[n-1] ? (x | ~m) : (x & m);
  endfunction

  always_comb begin
    unique case (bmx_op_e'(op))
      OP_AND:    y = a & b;
      OP_XOR:    y = a ^ b;
      OP_INV:    y = ~b;
      OP_OR:     y = a | b;
      OP_ANDN:   y = a & ~b;
      OP_XNOR:   y = a ^ ~b;
      OP_PCNT:   y = set_count(b);
      OP_ORN:    y = a | ~b;
      OP_LZC:    y = lead_zeros(b);
      OP_TZC:    y = trail_zeros(b);
      OP_PKW_LO: y = pack_lanes(a, b, LANE_W, 1'b0);
      OP_PKW_HI: y = pack_lanes(a, b, LANE_W, 1'b1);
      OP_PKH_LO: y = pack_lanes(a, b, LANE_H, 1'b0);
      OP_PKH_HI: y = pack_lanes(a, b, LANE_H, 1'b1);
      OP_PKB_LO: y = pack_lanes(a, b, LANE_B, 1'b0);
      OP_PKB_HI: y = pack_lanes(a, b, LANE_B, 1'b1);
      OP_SXW:    y = sign_from(b, LANE_W);
      OP_SXH:    y = sign_from(b, LANE_H);
      OP_SXB:    y = sign_from(b, LANE_B);
      default:   y = '0;
    endcase
  end

endmodule

// File: rtl/bmx_shift_unit.sv
// Shifts, rotates, generalized reverse and butterfly shuffle (codes 0x13..0x19).
module bmx_shift_unit
  import bmx_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic [7:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  localparam int unsigned SHW   = $clog2(W);
  localparam int unsigned SHF_N = SHW - 1;

  // Bits whose index has bit k equal to 'want'.
  function automatic logic [W-1:0] index_bit_mask(input int unsigned k,
                                                  input logic want);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (((i >> k) & 1) == int'(want));
    return m;
  endfunction

  logic [SHW-1:0]   amt;
  logic [2*W-1:0]   rol_wide;
  logic [2*W-1:0]   ror_wide;
  logic [W-1:0]     grev_stage [SHW+1];
  logic [W-1:0]     shfl_stage [SHF_N+1];

  assign amt      = b[SHW-1:0];
  assign rol_wide = {a, a} << amt;
  assign ror_wide = {a, a} >> amt;

  // Generalized reverse: stage k swaps neighbouring groups of 2**k bits.
  assign grev_stage[0] = a;
  for (genvar k = 0; k < SHW; k++) begin : g_grev
    localparam logic [W-1:0] LOW_GRP = index_bit_mask(k, 1'b0);
    assign grev_stage[k+1] = b[k]
      ? (((grev_stage[k] & LOW_GRP) << (1 << k)) |
         ((grev_stage[k] >> (1 << k)) & LOW_GRP))
      : grev_stage[k];
  end

  // Butterfly shuffle: outermost stage first, each exchanging index bits k and k+1.
  assign shfl_stage[0] = a;
  for (genvar j = 0; j < SHF_N; j++) begin : g_shfl
    localparam int unsigned K = SHF_N - 1 - j;
    localparam logic [W-1:0] TO_UP =
      index_bit_mask(K + 1, 1'b1) & index_bit_mask(K, 1'b0);
    localparam logic [W-1:0] TO_DN =
      index_bit_mask(K + 1, 1'b0) & index_bit_mask(K, 1'b1);
    assign shfl_stage[j+1] = b[K]
      ? ((shfl_stage[j] & ~(TO_UP | TO_DN)) |
         ((shfl_stage[j] << (1 << K)) & TO_UP) |
         ((shfl_stage[j] >> (1 << K)) & TO_DN))
      : shfl_stage[j];
  end

  always_comb begin
    unique case (bmx_op_e'(op))
      OP_SRA:  y = $unsigned($signed(a) >>> amt);
      OP_SLL:  y = a << amt;
      OP_SRL:  y = a >> amt;
      OP_ROTL: y = rol_wide[2*W-1:W];
      OP_ROTR: y = ror_wide[W-1:0];
      OP_GREV: y = grev_stage[SHW];
      OP_SHFL: y = shfl_stage[SHF_N];
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/bmx_gather_unit.sv
// Masked parallel bit gather and scatter (codes 0x1A, 0x1B).
module bmx_gather_unit
  import bmx_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         scatter,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  function automatic logic [W-1:0] gather_bits(input logic [W-1:0] d,
                                               input logic [W-1:0] m);
    logic [W-1:0] r = '0;
    int unsigned  j = 0;
    for (int i = 0; i < W; i++) begin
      if (m[i]) begin
        r[j] = d[i];
        j++;
      end
    end
    return r;
  endfunction

  function automatic logic [W-1:0] scatter_bits(input logic [W-1:0] d,
                                                input logic [W-1:0] m);
    logic [W-1:0] r = '0;
    int unsigned  j = 0;
    for (int i = 0; i < W; i++) begin
      if (m[i]) begin
        r[i] = d[j];
        j++;
      end
    end
    return r;
  endfunction

  logic [W-1:0] gathered;
  logic [W-1:0] scattered;

  assign gathered  = gather_bits(a, b);
  assign scattered = scatter_bits(a, b);
  assign y         = scatter ? scattered : gathered;

endmodule

// File: rtl/bmx_alu.sv
// Top: decodes the family, selects the unit result and registers it.
module bmx_alu
  import bmx_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [7:0]   in_op,
  input  logic [W-1:0] in_dst,
  input  logic [W-1:0] in_src,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  // Named decode events, observed by the assertions below.
  logic         op_known;
  logic         fire;
  logic         sel_bitwise;
  logic         sel_shift;
  logic         sel_gather;
  logic [W-1:0] bitwise_y;
  logic [W-1:0] shift_y;
  logic [W-1:0] gather_y;
  logic [W-1:0] result_next;

  assign op_known    = (in_op <= LAST_OP);
  assign fire        = in_valid & op_known;
  assign sel_bitwise = (in_op <= LAST_BITWISE);
  assign sel_shift   = (in_op > LAST_BITWISE) && (in_op <= LAST_SHIFT);
  assign sel_gather  = (in_op > LAST_SHIFT) && op_known;

  bmx_bitwise_unit #(.W(W)) bitwise_i (
    .op(in_op), .a(in_dst), .b(in_src), .y(bitwise_y)
  );

  bmx_shift_unit #(.W(W)) shift_i (
    .op(in_op), .a(in_dst), .b(in_src), .y(shift_y)
  );

  bmx_gather_unit #(.W(W)) gather_i (
    .scatter(in_op[0]), .a(in_dst), .b(in_src), .y(gather_y)
  );

  always_comb begin
    result_next = '0;
    if (sel_bitwise) result_next = bitwise_y;
    if (sel_shift)   result_next = shift_y;
    if (sel_gather)  result_next = gather_y;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= fire;
      if (fire) out_data <= result_next;
    end
  end

  // R1: strobe follows an accepted request by one cycle
  a_r1_strobe_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);
  // R1: unhandled codes or idle cycles give no strobe
  a_r1_no_strobe_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !out_valid);
  // R14: result held while no strobe
  a_r14_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
  // R4: a population count never exceeds the word width
  a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_PCNT) |=> (out_data <= W));
  // R5: zero counts never exceed the word width
  a_r5_zeros_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_op == OP_LZC || in_op == OP_TZC)) |=> (out_data <= W));
  // R6: narrow packs leave the upper half clear
  a_r6_narrow_pack_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_op == OP_PKH_LO || in_op == OP_PKB_LO)) |=>
      (out_data[W-1:W/2] == '0));
  // R8: word sign extension gives a uniform upper part
  a_r8_sign_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_SXW) |=>
      ($countones(out_data[W-1:W/2-1]) == 0 ||
       $countones(out_data[W-1:W/2-1]) == W/2 + 1));
  // R9: rotates preserve the number of set bits
  a_r9_rotate_keeps_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_op == OP_ROTL || in_op == OP_ROTR)) |=>
      ($countones(out_data) == $countones($past(in_dst))));
  // R10: reverse is a permutation
  a_r10_reverse_keeps_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_GREV) |=>
      ($countones(out_data) == $countones($past(in_dst))));
  // R11: shuffle is a permutation
  a_r11_shuffle_keeps_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_SHFL) |=>
      ($countones(out_data) == $countones($past(in_dst))));
  // R12: a gather yields no more ones than the mask selects
  a_r12_gather_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_GATHER) |=>
      ($countones(out_data) <= $countones($past(in_src))));
  // R13: a scatter only lands on mask positions
  a_r13_scatter_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_SCATTER) |=>
      ((out_data & ~$past(in_src)) == '0));

endmodule

// File: tb/bmx_alu_tb_top.sv
`timescale 1ns/1ps
module bmx_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_op = 8'h00;
  logic [63:0] in_dst = '0;
  logic [63:0] in_src = '0;
  logic        out_valid;
  logic [63:0] out_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;
  logic [63:0] last_result = '0;

  always #2.5 clk = ~clk;

  bmx_alu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_dst(in_dst), .in_src(in_src), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic next_rand(output logic [63:0] v);
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    v = rng;
  endtask

  task automatic check(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  // ---- reference model, written from the requirements ----
  function automatic logic [63:0] m_pop(input logic [63:0] x);
    logic [63:0] t = x;
    int n = 0;
    while (t != 0) begin t = t & (t - 1); n++; end
    return 64'(n);
  endfunction

  function automatic logic [63:0] m_lz(input logic [63:0] x);
    logic [63:0] t = x;
    int n = 0;
    while (n < 64 && !t[63]) begin t = t << 1; n++; end
    return 64'(n);
  endfunction

  function automatic logic [63:0] m_tz(input logic [63:0] x);
    logic [63:0] t = x;
    int n = 0;
    while (n < 64 && !t[0]) begin t = t >> 1; n++; end
    return 64'(n);
  endfunction

  function automatic logic [63:0] m_sext(input logic [63:0] x, input int n);
    logic signed [63:0] t = $signed(x << (64 - n));
    return $unsigned(t >>> (64 - n));
  endfunction

  function automatic logic [63:0] m_shift(input logic [7:0] op,
                                          input logic [63:0] d, input int s);
    logic [63:0] r = '0;
    for (int i = 0; i < 64; i++) begin
      case (op)
        8'h13: r[i] = (i + s < 64) ? d[i + s] : d[63];
        8'h14: r[i] = (i >= s) ? d[i - s] : 1'b0;
        8'h15: r[i] = (i + s < 64) ? d[i + s] : 1'b0;
        8'h16: r[i] = d[(i - s + 64) % 64];
        default: r[i] = d[(i + s) % 64];
      endcase
    end
    return r;
  endfunction

  function automatic logic [63:0] m_grev(input logic [63:0] d, input int c);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = d[i ^ c];
    return r;
  endfunction

  function automatic int swap_idx(input int i, input int k);
    int lo = (i >> k) & 1;
    int hi = (i >> (k + 1)) & 1;
    int base = i & ~(3 << k);
    return base | (lo << (k + 1)) | (hi << k);
  endfunction

  function automatic logic [63:0] m_shfl(input logic [63:0] d, input int c);
    logic [63:0] x = d;
    logic [63:0] r;
    for (int k = 4; k >= 0; k--) begin
      if (((c >> k) & 1) == 1) begin
        for (int i = 0; i < 64; i++) r[swap_idx(i, k)] = x[i];
        x = r;
      end
    end
    return x;
  endfunction

  function automatic logic [63:0] m_gather(input logic [63:0] d, input logic [63:0] m);
    logic [63:0] t = m;
    logic [63:0] r = '0;
    int j = 0;
    while (t != 0) begin
      r[j] = d[m_tz(t)];
      t = t & (t - 1);
      j++;
    end
    return r;
  endfunction

  function automatic logic [63:0] m_scatter(input logic [63:0] d, input logic [63:0] m);
    logic [63:0] t = m;
    logic [63:0] r = '0;
    int j = 0;
    while (t != 0) begin
      r[m_tz(t)] = d[j];
      t = t & (t - 1);
      j++;
    end
    return r;
  endfunction

  function automatic logic [63:0] model(input logic [7:0] op,
                                        input logic [63:0] d, input logic [63:0] s);
    case (op)
      8'h00: return d & s;
      8'h01: return d ^ s;
      8'h02: return ~s;
      8'h03: return d | s;
      8'h04: return d & ~s;
      8'h05: return ~(d ^ s);
      8'h06: return m_pop(s);
      8'h07: return d | ~s;
      8'h08: return m_lz(s);
      8'h09: return m_tz(s);
      8'h0A: return {s[31:0], d[31:0]};
      8'h0B: return {s[63:32], d[63:32]};
      8'h0C: return {32'h0, s[15:0], d[15:0]};
      8'h0D: return {32'h0, s[31:16], d[31:16]};
      8'h0E: return {48'h0, s[7:0], d[7:0]};
      8'h0F: return {48'h0, s[15:8], d[15:8]};
      8'h10: return m_sext(s, 32);
      8'h11: return m_sext(s, 16);
      8'h12: return m_sext(s, 8);
      8'h13, 8'h14, 8'h15, 8'h16, 8'h17: return m_shift(op, d, int'(s[5:0]));
      8'h18: return m_grev(d, int'(s[5:0]));
      8'h19: return m_shfl(d, int'(s[4:0]));
      8'h1A: return m_gather(d, s);
      default: return m_scatter(d, s);
    endcase
  endfunction

  function automatic string req_of(input logic [7:0] op);
    if (op == 8'h06) return "R4";
    if (op <= 8'h07) return "R3";
    if (op <= 8'h09) return "R5";
    if (op <= 8'h0F) return op[0] ? "R7" : "R6";
    if (op <= 8'h12) return "R8";
    if (op <= 8'h17) return "R9";
    if (op == 8'h18) return "R10";
    if (op == 8'h19) return "R11";
    if (op == 8'h1A) return "R12";
    return "R13";
  endfunction

  // Drive one request on the falling edge, check one cycle later.
  task automatic run_op(input logic [7:0] op, input logic [63:0] d, input logic [63:0] s);
    logic [63:0] e = model(op, d, s);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_dst = d; in_src = s;
    @(posedge clk); #0.5;
    check("R1", $sformatf("strobe op=%02h", op), 64'(out_valid), 64'd1);
    check(req_of(op), $sformatf("op=%02h d=%h s=%h", op, d, s), out_data, e);
    last_result = e;
  endtask

  // A cycle with no accepted request: no strobe, result held (R1, R14).
  task automatic run_quiet(input logic v, input logic [7:0] op);
    logic [63:0] rd;
    logic [63:0] rs;
    next_rand(rd);
    next_rand(rs);
    @(negedge clk);
    in_valid = v; in_op = op; in_dst = rd; in_src = rs;
    @(posedge clk); #0.5;
    check("R1", $sformatf("no strobe v=%0d op=%02h", v, op), 64'(out_valid), 64'd0);
    check("R14", $sformatf("held v=%0d op=%02h", v, op), out_data, last_result);
  endtask

  function automatic logic [63:0] corner(input int k);
    case (k)
      0: return 64'h0;
      1: return '1;
      2: return 64'h1;
      3: return 64'h8000_0000_0000_0000;
      4: return 64'h0000_0000_8000_0000;
      5: return 64'h0000_0000_0000_8000;
      6: return 64'h0000_0000_0000_0080;
      7: return 64'h0000_0000_7FFF_FF7F;
      8: return 64'hAAAA_AAAA_AAAA_AAAA;
      default: return 64'h0123_4567_89AB_CDEF;
    endcase
  endfunction

  initial begin
    logic [63:0] r1;
    logic [63:0] r2;
    // R2: reset state
    repeat (3) @(posedge clk);
    #0.5;
    check("R2", "valid in reset", 64'(out_valid), 64'd0);
    check("R2", "data in reset", out_data, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // every handled code against corner operand pairs and random pairs
    for (int op = 0; op <= 8'h1B; op++) begin
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j += 3)
          run_op(8'(op), corner(i), corner(j));
      for (int n = 0; n < 20; n++) begin
        next_rand(r1);
        next_rand(r2);
        run_op(8'(op), r1, r2);
      end
      run_quiet(1'b0, 8'(op));
    end

    // R9: every shift amount, with garbage in the ignored upper bits
    for (int op = 8'h13; op <= 8'h17; op++)
      for (int a = 0; a < 64; a++) begin
        next_rand(r1);
        next_rand(r2);
        run_op(8'(op), r1, {r2[63:6], 6'(a)});
      end

    // R10 / R11: every control value, upper bits randomized
    for (int c = 0; c < 64; c++) begin
      next_rand(r1);
      next_rand(r2);
      run_op(8'h18, r1, {r2[63:6], 6'(c)});
    end
    for (int c = 0; c < 32; c++) begin
      next_rand(r1);
      next_rand(r2);
      run_op(8'h19, r1, {r2[63:5], 5'(c)});
    end

    // R5 / R4: each single set bit
    for (int b = 0; b < 64; b++) begin
      run_op(8'h08, '0, 64'h1 << b);
      run_op(8'h09, '0, 64'h1 << b);
      run_op(8'h06, '0, ~(64'h1 << b));
    end

    // R1 / R14: every unhandled code, then idle cycles
    run_op(8'h01, 64'hDEAD_BEEF_0000_FFFF, 64'h1234_5678_9ABC_DEF0);
    for (int op = 8'h1C; op <= 8'hFF; op++) run_quiet(1'b1, 8'(op));
    for (int k = 0; k < 8; k++) run_quiet(1'b0, 8'(k));

    @(negedge clk);
    in_valid = 1'b0;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule